// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a processor's fetch and execute logic. It watches for an end-of-instruction strobe and, on each one, decides whether to leave the running program for a service routine. If it does, it keeps the program counter of the instruction that just finished. It then hands the fetch logic a new program counter and a one-cycle load strobe. A later return strobe from the routine makes it reload the kept value, and execution resumes at the interrupted point.

The routine address for the maskable request comes from one of three sources. It can be a fixed constant. It can be an address that the peripheral places on the data bus after an acknowledge. Or the peripheral can place an index on the bus, and the block uses it to fetch the address from a table through a simple request/valid port.

A second, non-maskable request line ignores the mask, wins over the maskable line and has its own fixed address. While a routine runs, the block accepts no further request, so a request line that stays high cannot re-enter.

Top module: `trap_sequencer`

## Requirements
- R1: Request lines are looked at only in a cycle where `instrDone` is high. With `instrDone` low, no acknowledge and no load strobe appear, however the request lines behave.
- R2: On entry, `savedPc` takes the value `curPc` had in the boundary cycle.
- R3: With `entryMode` 2'b00 (or the spare code 2'b11), an accepted maskable request gives `pcLoad` high for one cycle, one cycle after the boundary, with `pcNext` = FIX_ADDR (default 16). `intAck` stays low.
- R4: With `entryMode` 2'b01, `intAck` rises one cycle after the boundary. One cycle after that, `pcLoad` pulses and `pcNext` equals the `busData` value seen while `intAck` was high.
- R5: With `entryMode` 2'b10, `intAck` pulses as in R4. The low IDX_W bits of `busData` then go out on `tblIdx` with `tblReq` high. The cycle after `tblValid` is seen, `pcLoad` pulses with `pcNext` = `tblData`, not the bus value.
- R6: With `irqMask` high, a maskable request at a boundary is ignored: no acknowledge and no load strobe follow.
- R7: `nmiReq` at a boundary is taken whatever `irqMask` is, and it wins over `irqReq`. It loads `pcNext` = NMI_ADDR (default 8) without an acknowledge.
- R8: A `retStrobe` during a routine gives a one-cycle `pcLoad` with `pcNext` equal to `savedPc`.
- R9: From entry until return, further boundaries are ignored even when both request lines are high.
- R10: `intAck` is high for exactly one cycle per vectored or table entry, and it never coincides with `pcLoad` or `tblReq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | Current instruction completes this cycle |
| curPc | input | PC_W | Program counter of the completing instruction |
| irqReq | input | 1 | Maskable request, level |
| nmiReq | input | 1 | Non-maskable request, level |
| irqMask | input | 1 | 1 = ignore irqReq |
| entryMode | input | 2 | 00 fixed, 01 vectored, 10 table, 11 fixed |
| busData | input | PC_W | Data bus from the peripheral |
| retStrobe | input | 1 | Routine returns |
| tblValid | input | 1 | Table word valid |
| tblData | input | PC_W | Table word |
| tblReq | output | 1 | Table word requested |
| tblIdx | output | IDX_W | Table index |
| intAck | output | 1 | Interrupt acknowledge |
| pcLoad | output | 1 | Load pcNext into the program counter |
| pcNext | output | PC_W | New program counter |
| savedPc | output | PC_W | Program counter kept at entry |

## Verification
The assertions assume several things about the inputs. `entryMode` and `busData` hold steady from the accepted boundary until the bus value is taken. `tblValid` is raised only while `tblReq` is high. `retStrobe` comes only while a routine is active. The stimulus meets these assumptions by construction. Each random episode fixes the mode and bus value before the boundary and holds them through capture. It answers the table port only after `tblReq` is seen, and it pulses the return strobe only after checking that the routine was entered.

// File: rtl/trapseq_pkg.sv
package trapseq_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED  = 2'b00,
    MODE_VECTOR = 2'b01,
    MODE_TABLE  = 2'b10,
    MODE_SPARE  = 2'b11
  } entryMode_e;

  typedef enum logic [2:0] {
    SEL_FIXED,
    SEL_NMI,
    SEL_BUS,
    SEL_TBL,
    SEL_RET
  } pcSel_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_ACK,
    ST_TBLWAIT,
    ST_SERVE
  } seqState_e;

  typedef struct packed {
    logic   savePc;
    logic   loadPc;
    pcSel_e pcSel;
    logic   grabIdx;
  } dpCtrl_t;
endpackage

// File: rtl/trapseq_ctrl.sv
module trapseq_ctrl
  import trapseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrDone,
  input  logic       irqReq,
  input  logic       nmiReq,
  input  logic       irqMask,
  input  logic [1:0] entryMode,
  input  logic       retStrobe,
  input  logic       tblValid,
  output logic       intAck,
  output logic       tblReq,
  output dpCtrl_t    dpCtl
);
  seqState_e  state, nextState;
  entryMode_e modeQ;
  entryMode_e modeIn;

  assign modeIn = entryMode_e'(entryMode);

  always_comb begin
    nextState     = state;
    dpCtl.savePc  = 1'b0;
    dpCtl.loadPc  = 1'b0;
    dpCtl.pcSel   = SEL_FIXED;
    dpCtl.grabIdx = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (instrDone) begin
          if (nmiReq) begin
            dpCtl.savePc = 1'b1;
            dpCtl.loadPc = 1'b1;
            dpCtl.pcSel  = SEL_NMI;
            nextState    = ST_SERVE;
          end else if (irqReq && !irqMask) begin
            dpCtl.savePc = 1'b1;
            if (modeIn == MODE_VECTOR || modeIn == MODE_TABLE) begin
              nextState = ST_ACK;
            end else begin
              dpCtl.loadPc = 1'b1;
              dpCtl.pcSel  = SEL_FIXED;
              nextState    = ST_SERVE;
            end
          end
        end
      end
      ST_ACK: begin
        if (modeQ == MODE_TABLE) begin
          dpCtl.grabIdx = 1'b1;
          nextState     = ST_TBLWAIT;
        end else begin
          dpCtl.loadPc = 1'b1;
          dpCtl.pcSel  = SEL_BUS;
          nextState    = ST_SERVE;
        end
      end
      ST_TBLWAIT: begin
        if (tblValid) begin
          dpCtl.loadPc = 1'b1;
          dpCtl.pcSel  = SEL_TBL;
          nextState    = ST_SERVE;
        end
      end
      ST_SERVE: begin
        if (retStrobe) begin
          dpCtl.loadPc = 1'b1;
          dpCtl.pcSel  = SEL_RET;
          nextState    = ST_RUN;
        end
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
      modeQ <= MODE_FIXED;
    end else begin
      state <= nextState;
      if (state == ST_RUN) modeQ <= modeIn;
    end
  end

  assign intAck = (state == ST_ACK);
  assign tblReq = (state == ST_TBLWAIT);
endmodule

// File: rtl/trapseq_dp.sv
module trapseq_dp
  import trapseq_pkg::*;
#(
  parameter int unsigned PC_W     = 16,
  parameter int unsigned IDX_W    = 8,
  parameter logic [PC_W-1:0] FIX_ADDR = 16,
  parameter logic [PC_W-1:0] NMI_ADDR = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtl,
  input  logic [PC_W-1:0]  curPc,
  input  logic [PC_W-1:0]  busData,
  input  logic [PC_W-1:0]  tblData,
  output logic [IDX_W-1:0] tblIdx,
  output logic             pcLoad,
  output logic [PC_W-1:0]  pcNext,
  output logic [PC_W-1:0]  savedPc
);
  logic [PC_W-1:0] target;

  always_comb begin
    unique case (dpCtl.pcSel)
      SEL_NMI: target = NMI_ADDR;
      SEL_BUS: target = busData;
      SEL_TBL: target = tblData;
      SEL_RET: target = savedPc;
      default: target = FIX_ADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcLoad  <= 1'b0;
      pcNext  <= '0;
      savedPc <= '0;
      tblIdx  <= '0;
    end else begin
      pcLoad <= dpCtl.loadPc;
      if (dpCtl.loadPc)  pcNext  <= target;
      if (dpCtl.savePc)  savedPc <= curPc;
      if (dpCtl.grabIdx) tblIdx  <= busData[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trapseq_pkg::*;
#(
  parameter int unsigned PC_W     = 16,
  parameter int unsigned IDX_W    = 8,
  parameter logic [PC_W-1:0] FIX_ADDR = 16,
  parameter logic [PC_W-1:0] NMI_ADDR = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrDone,
  input  logic [PC_W-1:0]  curPc,
  input  logic             irqReq,
  input  logic             nmiReq,
  input  logic             irqMask,
  input  logic [1:0]       entryMode,
  input  logic [PC_W-1:0]  busData,
  input  logic             retStrobe,
  input  logic             tblValid,
  input  logic [PC_W-1:0]  tblData,
  output logic             tblReq,
  output logic [IDX_W-1:0] tblIdx,
  output logic             intAck,
  output logic             pcLoad,
  output logic [PC_W-1:0]  pcNext,
  output logic [PC_W-1:0]  savedPc
);
  dpCtrl_t dpCtl;

  trapseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .irqReq(irqReq),
    .nmiReq(nmiReq), .irqMask(irqMask), .entryMode(entryMode),
    .retStrobe(retStrobe), .tblValid(tblValid), .intAck(intAck),
    .tblReq(tblReq), .dpCtl(dpCtl)
  );

  trapseq_dp #(
    .PC_W(PC_W), .IDX_W(IDX_W), .FIX_ADDR(FIX_ADDR), .NMI_ADDR(NMI_ADDR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .curPc(curPc),
    .busData(busData), .tblData(tblData), .tblIdx(tblIdx),
    .pcLoad(pcLoad), .pcNext(pcNext), .savedPc(savedPc)
  );
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             instrDone,
  input logic [PC_W-1:0]  curPc,
  input logic [1:0]       entryMode,
  input logic [PC_W-1:0]  busData,
  input logic             tblValid,
  input logic [PC_W-1:0]  tblData,
  input logic             tblReq,
  input logic             intAck,
  input logic             pcLoad,
  input logic [PC_W-1:0]  pcNext,
  input logic [PC_W-1:0]  savedPc
);
  assert_ack_at_boundary_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intAck) |-> $past(instrDone));

  assert_pc_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intAck) |-> savedPc == $past(curPc));

  assert_vector_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && entryMode == 2'b01) |=> (pcLoad && pcNext == $past(busData)));

  assert_table_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tblReq && tblValid) |=> (pcLoad && pcNext == $past(tblData)));

  assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> !intAck);

  assert_ack_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({intAck, tblReq, pcLoad}));
endmodule

bind trap_sequencer trap_sequencer_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rstN(rstN), .instrDone(instrDone), .curPc(curPc),
  .entryMode(entryMode), .busData(busData), .tblValid(tblValid),
  .tblData(tblData), .tblReq(tblReq), .intAck(intAck), .pcLoad(pcLoad),
  .pcNext(pcNext), .savedPc(savedPc)
);

// File: tb/trap_sequencer_tb.sv
module trap_sequencer_tb_top;
  localparam int PC_W = 16;
  localparam int IDX_W = 8;
  localparam logic [PC_W-1:0] FIXA = 16;
  localparam logic [PC_W-1:0] NMIA = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrDone = 0, irqReq = 0, nmiReq = 0, irqMask = 0;
  logic retStrobe = 0, tblValid = 0;
  logic [1:0] entryMode = 0;
  logic [PC_W-1:0] curPc = 0, busData = 0, tblData = 0;
  logic tblReq, intAck, pcLoad;
  logic [IDX_W-1:0] tblIdx;
  logic [PC_W-1:0] pcNext, savedPc;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  trap_sequencer dut_i (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .curPc(curPc),
    .irqReq(irqReq), .nmiReq(nmiReq), .irqMask(irqMask),
    .entryMode(entryMode), .busData(busData), .retStrobe(retStrobe),
    .tblValid(tblValid), .tblData(tblData), .tblReq(tblReq),
    .tblIdx(tblIdx), .intAck(intAck), .pcLoad(pcLoad), .pcNext(pcNext),
    .savedPc(savedPc)
  );

  function automatic logic [PC_W-1:0] tblWord(input logic [IDX_W-1:0] idx);
    return 16'h4000 + {idx, 2'b00} + 16'd3;
  endfunction

  task automatic check(input string req, input logic [PC_W-1:0] act,
                       input logic [PC_W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic episode(input bit nmi, input bit irq, input bit mask,
                         input logic [1:0] mode, input logic [PC_W-1:0] bus,
                         input logic [PC_W-1:0] pc);
    bit take;
    logic [PC_W-1:0] expPc;
    irqReq = irq; nmiReq = nmi; irqMask = mask;
    entryMode = mode; busData = bus; curPc = pc;
    // R1: requests without a boundary do nothing
    step();
    check("R1 ack", intAck, 0);
    check("R1 load", pcLoad, 0);
    instrDone = 1;
    step();
    instrDone = 0;
    take = nmi || (irq && !mask);
    if (!take) begin
      check("R6 ack", intAck, 0);
      check("R6 load", pcLoad, 0);
      step();
      check("R6 load late", pcLoad, 0);
    end else begin
      if (nmi) begin
        check("R7 load", pcLoad, 1);
        check("R7 addr", pcNext, NMIA);
        check("R7 ack", intAck, 0);
      end else if (mode == 2'b01) begin
        check("R4 ack", intAck, 1);
        check("R4 noload", pcLoad, 0);
        step();
        check("R4 load", pcLoad, 1);
        check("R4 addr", pcNext, bus);
        check("R10 ackdrop", intAck, 0);
      end else if (mode == 2'b10) begin
        check("R5 ack", intAck, 1);
        step();
        check("R10 ackdrop", intAck, 0);
        check("R5 req", tblReq, 1);
        check("R5 idx", {8'h00, tblIdx}, {8'h00, bus[IDX_W-1:0]});
        step();
        check("R5 wait", pcLoad, 0);
        tblValid = 1;
        tblData = tblWord(tblIdx);
        step();
        tblValid = 0;
        check("R5 load", pcLoad, 1);
        check("R5 addr", pcNext, tblWord(bus[IDX_W-1:0]));
        check("R5 req drop", tblReq, 0);
      end else begin
        check("R3 load", pcLoad, 1);
        check("R3 addr", pcNext, FIXA);
        check("R3 ack", intAck, 0);
      end
      check("R2 saved", savedPc, pc);
      // R9: requests held high, another boundary is ignored
      nmiReq = 1; irqReq = 1; irqMask = 0;
      curPc = pc + 16'd2;
      instrDone = 1;
      step();
      instrDone = 0;
      check("R9 load", pcLoad, 0);
      check("R9 ack", intAck, 0);
      retStrobe = 1;
      step();
      retStrobe = 0;
      expPc = pc;
      check("R8 load", pcLoad, 1);
      check("R8 addr", pcNext, expPc);
    end
    irqReq = 0; nmiReq = 0;
    step();
    check("R8 pulse", pcLoad, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    check("reset load", pcLoad, 0);
    check("reset ack", intAck, 0);
    check("reset req", tblReq, 0);
    rstN = 1;
    step();
    // directed corners
    episode(0, 1, 0, 2'b00, 16'h1234, 16'd100);   // R3
    episode(0, 1, 0, 2'b11, 16'h1234, 16'd102);   // R3 spare code
    episode(0, 1, 0, 2'b01, 16'h0200, 16'd104);   // R4
    episode(0, 1, 0, 2'b10, 16'hABFF, 16'd106);   // R5 top index
    episode(0, 1, 0, 2'b10, 16'h5500, 16'd108);   // R5 index 0
    episode(0, 1, 1, 2'b01, 16'h0300, 16'd110);   // R6
    episode(1, 1, 1, 2'b01, 16'h0300, 16'd112);   // R7 mask and priority
    episode(1, 0, 0, 2'b10, 16'h0300, 16'hFFFE);  // R7
    for (int i = 0; i < 300; i++) begin
      episode($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1,
              $urandom_range(0, 2) == 0, 2'($urandom_range(0, 3)),
              16'($urandom), 16'($urandom));
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule